// File: doc/BRIEF.md
# Unit-Interval Drift Calibration Engine

This block measures the true unit interval of one serial lane direction against a free-running time-of-day reference. A local time counter that advances by a fixed UI step drifts away from the reference whenever the lane clock's ppm offset changes. The measured UI lets software or a neighbouring block correct that step. Transmit and receive each use their own instance.

A start command records a first snapshot. This snapshot holds the 48-bit reference time (32 bits of integer ns and 16 fractional bits) and the 16-bit alignment-marker count, both captured on the same edge. After a programmed number of cycles the block records a second snapshot in the same way. It then derives the elapsed time, corrected for the one-second wrap, and the marker count difference, corrected for the 16-bit wrap. A plausibility bound built from the nominal UI rejects windows in which the 16-bit count could have wrapped more than once. A serial restoring divider then produces the UI, scaled by a quarter of the marker interval, as a 4.24 fixed-point nanosecond word. With `auto_repeat` set, each completed measurement starts the next one right away, so the UI tracks ppm changes.

Top module: `ui_calib`

## Requirements
- R1: A synchronous active-high `rst` drives `busy`, `ui_valid` and `err` low and `ui` to zero, and abandons any measurement in progress.
- R2: When `start` is high, the block is idle and `wait_cycles` >= MIN_WAIT (default 16), the block captures {`tod_hi`,`tod_lo`} and `marker_count` together on that edge and `busy` is high from the next cycle.
- R3: The second snapshot of time and count is taken exactly `wait_cycles` clock edges after the first. `wait_cycles` is latched at start.
- R4: Elapsed time is t1 - t0 when t1 > t0. Otherwise it is t1 + 48'h3B9A_CA00_0000 - t0, the constant being one second with 16 fractional bits.
- R5: Count difference is c1 - c0 when c1 >= c0, else c1 + 65536 - c0. If that difference times `marker_interval` is zero, no divide is done and `err` pulses with `err_code` = 2, one edge after the second snapshot.
- R6: If elapsed time x 256 exceeds 64000 x `marker_interval` x 650751 (the nominal UI of 38.7878 ps in 24-bit fractional ns), the result is discarded and `err` pulses with `err_code` = 3, one edge after the second snapshot. The zero check of R5 takes priority.
- R7: Otherwise `ui` = floor(elapsed x 1024 / (count difference x `marker_interval`)), which is elapsed / (count x interval / 4) in 4.24 ns format, saturated at 28'hFFFFFFF. `ui_valid` pulses for one cycle, 59 edges after the second snapshot.
- R8: A `start` while idle with `wait_cycles` < MIN_WAIT pulses `err` with `err_code` = 1 on the next cycle and leaves `busy` low.
- R9: `start` while `busy` is high is ignored and does not disturb the measurement in progress.
- R10: If `auto_repeat` is high on the edge where a measurement completes (with `ui_valid`, or with `err_code` 2 or 3), a new first snapshot is taken on that same edge and `busy` stays high, reusing the latched wait.
- R11: Without repetition, `busy` stays high from an accepted start until the edge that raises `ui_valid` or `err`. `ui_valid` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a measurement when idle |
| auto_repeat | input | 1 | Chain a new measurement after each completion |
| wait_cycles | input | WAIT_W | Cycles between the two snapshots |
| marker_interval | input | 16 | Static marker spacing used for scaling |
| tod_lo | input | 32 | Reference time, low word |
| tod_hi | input | 16 | Reference time, high word |
| marker_count | input | 16 | Free-running marker counter |
| busy | output | 1 | Measurement in progress |
| ui_valid | output | 1 | One-cycle pulse: `ui` updated |
| err | output | 1 | One-cycle pulse: measurement rejected |
| err_code | output | 2 | 1 short wait, 2 zero divisor, 3 count may have wrapped |
| ui | output | 28 | Measured UI, 4 integer and 24 fractional ns bits |

## Verification
A snapshot taken on the wrong edge, or time and count taken on different edges, shows up as a `ui` value that differs from the bench's prediction on the very cycle `ui_valid` rises. A stuck or miscounted wait or divide counter moves the `ui_valid` or `err` edge by a cycle, and the per-clock comparison of `busy`, `ui_valid` and `err` flags that at once. A wrong wrap correction, bound or saturation shows as a wrong value or a wrong `err_code` at the end of the window where the rule applies.

// File: rtl/ui_calib.sv
module ui_calib #(
  parameter int WAIT_W    = 20,
  parameter int MIN_WAIT  = 16,
  parameter int EST_LIMIT = 64000,
  parameter int NOM_UI    = 650751
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              auto_repeat,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic [15:0]       marker_interval,
  input  logic [31:0]       tod_lo,
  input  logic [15:0]       tod_hi,
  input  logic [15:0]       marker_count,
  output logic              busy,
  output logic              ui_valid,
  output logic              err,
  output logic [1:0]        err_code,
  output logic [27:0]       ui
);
  localparam logic [47:0]       ONE_SEC = 48'h3B9A_CA00_0000;
  localparam int                DIV_N   = 58;
  localparam int                DC_W    = $clog2(DIV_N + 1);
  localparam logic [DC_W-1:0]   DC_LOAD = DC_W'(DIV_N);
  localparam logic [DC_W-1:0]   DC_ONE  = DC_W'(1);
  localparam logic [WAIT_W-1:0] W_ONE   = WAIT_W'(1);
  localparam logic [WAIT_W-1:0] W_MIN   = WAIT_W'(MIN_WAIT);
  localparam logic [55:0]       EST_K   = 56'(EST_LIMIT) * 56'(NOM_UI);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CALC, S_DIV} st_t;
  st_t st;

  logic [47:0]       t0, t1;
  logic [15:0]       c0, c1;
  logic [WAIT_W-1:0] wlen, wcnt;
  logic [DC_W-1:0]   dcnt;
  logic [31:0]       dvsr, rem;
  logic [57:0]       quo;

  wire [47:0] tod    = {tod_hi, tod_lo};
  wire [47:0] delta  = (t1 > t0) ? t1 - t0 : t1 + ONE_SEC - t0;
  wire [15:0] cdiff  = c1 - c0;
  wire [31:0] prod   = cdiff * marker_interval;
  wire        toolong = {delta, 8'd0} > EST_K * 56'(marker_interval);

  wire [32:0] shifted = {rem, quo[57]};
  wire [33:0] trial   = {1'b0, shifted} - {2'b00, dvsr};
  wire        take    = !trial[33];
  wire [57:0] q_next  = {quo[56:0], take};
  wire [27:0] q_sat   = (q_next[57:28] != '0) ? 28'hFFF_FFFF : q_next[27:0];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      ui_valid <= 1'b0;
      err <= 1'b0;
      err_code <= 2'd0;
      ui <= '0;
      t0 <= '0; t1 <= '0; c0 <= '0; c1 <= '0;
      wlen <= '0; wcnt <= '0; dcnt <= '0;
      dvsr <= '0; rem <= '0; quo <= '0;
    end else begin
      ui_valid <= 1'b0;
      err <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            if (wait_cycles < W_MIN) begin
              err <= 1'b1;
              err_code <= 2'd1;
            end else begin
              t0 <= tod; c0 <= marker_count;
              wlen <= wait_cycles; wcnt <= wait_cycles;
              st <= S_WAIT;
            end
          end
        S_WAIT:
          if (wcnt == W_ONE) begin
            t1 <= tod; c1 <= marker_count;
            st <= S_CALC;
          end else begin
            wcnt <= wcnt - W_ONE;
          end
        S_CALC:
          if (prod == '0 || toolong) begin
            err <= 1'b1;
            err_code <= (prod == '0) ? 2'd2 : 2'd3;
            t0 <= tod; c0 <= marker_count; wcnt <= wlen;
            st <= auto_repeat ? S_WAIT : S_IDLE;
          end else begin
            dvsr <= prod; rem <= '0; quo <= {delta, 10'd0};
            dcnt <= DC_LOAD;
            st <= S_DIV;
          end
        S_DIV: begin
          rem  <= take ? trial[31:0] : shifted[31:0];
          quo  <= q_next;
          dcnt <= dcnt - DC_ONE;
          if (dcnt == DC_ONE) begin
            ui_valid <= 1'b1;
            ui <= q_sat;
            t0 <= tod; c0 <= marker_count; wcnt <= wlen;
            st <= auto_repeat ? S_WAIT : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_snap_coherent_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && wait_cycles >= W_MIN) |=>
      (busy && t0 == $past(tod) && c0 == $past(marker_count)));

  p_second_snap_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && wcnt == W_ONE) |=> (st == S_CALC && t1 == $past(tod) && c1 == $past(marker_count)));

  p_no_zero_div_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_DIV) |-> (dvsr != '0));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ui_valid |=> !ui_valid);

  p_short_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && wait_cycles < W_MIN) |=> (err && err_code == 2'd1 && !busy));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && start) |=> ($stable(t0) && $stable(c0)));

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    ui_valid |-> !err);
endmodule

// File: tb/test_ui_calib.sv
module test_ui_calib;
  localparam longint unsigned ONE_SEC = 64'h3B9A_CA00_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic auto_repeat = 1'b0;
  logic [19:0] wait_cycles = 20'd20;
  logic [15:0] marker_interval = 16'd20;
  logic [47:0] tod_r = '0;
  logic [15:0] am = '0;
  logic busy, ui_valid, err;
  logic [1:0] err_code;
  logic [27:0] ui;

  longint unsigned tstep = 0;
  logic [15:0] astep = '0;

  always #2.5 clk = ~clk;

  ui_calib i_ui_calib (
    .clk(clk), .rst(rst), .start(start), .auto_repeat(auto_repeat),
    .wait_cycles(wait_cycles), .marker_interval(marker_interval),
    .tod_lo(tod_r[31:0]), .tod_hi(tod_r[47:32]), .marker_count(am),
    .busy(busy), .ui_valid(ui_valid), .err(err), .err_code(err_code), .ui(ui));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // free-running stimulus, changed away from the active edge
  always @(negedge clk) begin
    longint unsigned nt;
    nt = longint'(tod_r) + tstep;
    if (nt >= ONE_SEC) nt = nt - ONE_SEC;
    tod_r <= nt[47:0];
    am <= am + astep;
  end

  // behavioural reference model
  bit m_busy = 0, m_valid = 0, m_err = 0;
  int m_code = 0;
  longint unsigned m_ui = 0;
  int phase = 0, left = 0, wl = 0, outc = 0;
  longint unsigned mt0, mc0, exp_ui;

  always @(posedge clk) begin
    longint unsigned mt1, mc1, d, cd, dv, q;
    m_valid = 0;
    m_err = 0;
    if (rst) begin
      m_busy = 0; phase = 0; m_ui = 0;
    end else if (!m_busy) begin
      if (start) begin
        if (wait_cycles < 16) begin
          m_err = 1; m_code = 1;
        end else begin
          m_busy = 1; phase = 1; mt0 = tod_r; mc0 = am;
          wl = int'(wait_cycles); left = wl;
        end
      end
    end else if (phase == 1) begin
      left--;
      if (left == 0) begin
        mt1 = tod_r; mc1 = am;
        d  = (mt1 > mt0) ? mt1 - mt0 : mt1 + ONE_SEC - mt0;
        cd = (mc1 >= mc0) ? mc1 - mc0 : mc1 + 65536 - mc0;
        dv = cd * marker_interval;
        if (dv == 0) outc = 2;
        else if (d * 256 > 64'd64000 * 64'd650751 * marker_interval) outc = 3;
        else begin
          outc = 0;
          q = (d * 1024) / dv;
          exp_ui = (q > 64'hFFF_FFFF) ? 64'hFFF_FFFF : q;
        end
        phase = 2;
        left = (outc == 0) ? 59 : 1;
      end
    end else begin
      left--;
      if (left == 0) begin
        if (outc == 0) begin m_valid = 1; m_ui = exp_ui; end
        else begin m_err = 1; m_code = outc; end
        if (auto_repeat) begin
          phase = 1; mt0 = tod_r; mc0 = am; left = wl;
        end else begin
          m_busy = 0; phase = 0;
        end
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == m_busy, "R11", "busy", busy, m_busy);
      chk(ui_valid == m_valid, cur_req, "ui_valid", ui_valid, m_valid);
      chk(err == m_err, cur_req, "err", err, m_err);
      if (m_valid) chk(ui == m_ui[27:0], cur_req, "ui", ui, m_ui);
      if (m_err) chk(err_code == 2'(m_code), cur_req, "err_code", err_code, m_code);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: cycles %0d expected below %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run(string req, int w, longint unsigned ts, logic [15:0] as, logic [15:0] iv,
                     longint unsigned t_init, logic [15:0] a_init);
    @(negedge clk);
    cur_req = req;
    wait_cycles = 20'(w); tstep = ts; astep = as; marker_interval = iv;
    tod_r = t_init[47:0]; am = a_init;
    pulse_start();
    repeat (w + 70) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs after reset
    chk(busy == 0 && ui_valid == 0 && err == 0, "R1", "flags", {busy, ui_valid, err}, 0);
    chk(ui == 0, "R1", "ui", ui, 0);
    rst = 1'b0;

    run("R2 R3 R7", 20, 64'h10000, 16'd1, 16'd20, 64'd1000 << 16, 16'd5);
    run("R2 R3 R7", 33, 64'h1A2B3, 16'd3, 16'd7, 64'd77 << 16, 16'd100);
    run("R4", 20, 64'h10000, 16'd1, 16'd20, ONE_SEC - 64'h50000, 16'd9);
    run("R4", 24, 64'h123456, 16'd2, 16'd40, ONE_SEC - 64'h1000, 16'd0);
    run("R5", 20, 64'h10000, 16'd1, 16'd20, 64'd500 << 16, 16'hFFF0);
    run("R5", 20, 64'h10000, 16'd0, 16'd20, 64'd500 << 16, 16'h1234);
    run("R5", 20, 64'h10000, 16'd1, 16'd0, 64'd500 << 16, 16'h1234);
    run("R6", 20, 64'h1000000, 16'd1, 16'd1, 64'd3 << 16, 16'd0);
    run("R7", 20, 64'h400000, 16'd1, 16'd1, 64'd3 << 16, 16'd0);
    run("R8", 5, 64'h10000, 16'd1, 16'd20, 64'd3 << 16, 16'd0);
    chk(busy == 0, "R8", "busy after short wait", busy, 0);

    // R9: second start while busy, with a different wait
    @(negedge clk);
    cur_req = "R9";
    wait_cycles = 20'd30; tstep = 64'h2468A; astep = 16'd1; marker_interval = 16'd12;
    pulse_start();
    repeat (8) @(negedge clk);
    wait_cycles = 20'd16;
    pulse_start();
    repeat (100) @(negedge clk);

    // R10: chained measurements
    cur_req = "R10";
    auto_repeat = 1'b1;
    wait_cycles = 20'd18;
    pulse_start();
    repeat (200) @(negedge clk);
    chk(busy == 1, "R10", "busy while repeating", busy, 1);
    auto_repeat = 1'b0;
    repeat (100) @(negedge clk);

    // R1: reset in the middle of a measurement
    cur_req = "R1";
    wait_cycles = 20'd20;
    pulse_start();
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 0 && ui_valid == 0 && err == 0, "R1", "flags after mid reset", {busy, ui_valid, err}, 0);
    chk(ui == 0, "R1", "ui after mid reset", ui, 0);
    rst = 1'b0;
    run("R2 R7", 20, 64'h10000, 16'd1, 16'd20, 64'd10 << 16, 16'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule